// File: doc/BRIEF.md
# Side-band master election controller

Every node sharing a half-duplex serial bus carries one copy of this controller. It decides whether the node becomes the single bus master that runs the serial clock, or stays a device and listens. Three shared wired-OR lines carry the election: a host hold request, a master-claim line and a bus-activity line. Each is active high and weakly pulled low. The controller senses the resolved level of each line and, for the two lines it may drive, produces a pull request. A pull request of 1 drives the line high. A pull request of 0 leaves the pin as an input.

A node with no master on the bus claims mastership in two randomized stages. It first waits a pseudo-random back-off, then pulls the master-claim line. It waits a second back-off, then pulls the activity line, fires a one-cycle strobe that starts its ID broadcast, and takes the master role. A node that remembers being master restarts at once. A node that remembers being a device first sits out a long hold-off. A host hold request, another node's claim, or a collision sends the node out of the master path. The serial shifter, the ID transmitter, collision sensing and role storage lie outside this block and reach it as plain level and pulse inputs.

Top module: `sideband_master_elect`

## Requirements
- R1: While reset is held, both role outputs, both pull requests, the clock enable and the ID strobe are all 0, and both role outputs are 0 until an election ends.
- R2: With `prev_master_i` = 0, the node waits one cycle plus HOLD_TICKS cycles before its first probe. Its first claim pull therefore rises 2 + HOLD_TICKS + d rising edges after reset release, with d taken from the LFSR after 1 + HOLD_TICKS steps.
- R3: A probe that sees the claim line high puts the node in the device role, with both pulls and the clock enable at 0.
- R4: Each back-off lasts d = MIN_TICKS + ((q[RAND_BITS-1:0] * (MAX_TICKS-MIN_TICKS+1)) >> RAND_BITS) cycles, where q is the LFSR value at the edge that starts the back-off. With `prev_master_i` = 1 and an idle bus, the claim pull rises 2 + d edges after reset release, with q one step past the seed.
- R5: The LFSR loads `seed_i` in reset, replacing an all-zero seed by 1. It then shifts left once per clock, taking into bit 0 the XOR of bits 15, 13, 12 and 10 (16-bit width).
- R6: After the first back-off the node pulls the claim line. After the second back-off it pulls the activity line, takes the master role, raises the clock enable and pulses `id_start_o` for exactly one cycle.
- R7: The attempt is abandoned, with a move to the device role and release of every pull, in two cases: the claim line is seen high during the first back-off, or the activity line is seen high during the second.
- R8: A high host hold request drops the clock enable in the same cycle, moves a master or contending node to the device role on the next edge, and keeps it there while the request stays high.
- R9: A collision flag while master drops the clock enable in the same cycle, releases both pulls and the master role on the next edge, and restarts the election.
- R10: A collision flag outside the master role has no effect.
- R11: A device whose claim line and host request are both low starts a new election.
- R12: The node keeps the activity line pulled from the ID strobe until `id_done_i`. After that, as master, it pulls the activity line exactly when `xfer_busy_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prev_master_i | input | 1 | Stored role from the last run, 1 = was master |
| seed_i | input | LFSR_W | Per-node LFSR seed |
| host_req_i | input | 1 | Resolved host hold request line |
| claim_line_i | input | 1 | Resolved master-claim line |
| act_line_i | input | 1 | Resolved bus-activity line |
| collision_i | input | 1 | Collision or lost-link flag from the serial side |
| id_done_i | input | 1 | ID broadcast finished |
| xfer_busy_i | input | 1 | Serial engine transmitting (master role) |
| role_master_o | output | 1 | Node is master |
| role_device_o | output | 1 | Node is device |
| claim_pull_o | output | 1 | Drive the master-claim line high |
| act_pull_o | output | 1 | Drive the activity line high |
| sclk_en_o | output | 1 | Serial clock enable |
| id_start_o | output | 1 | One-cycle strobe starting the ID broadcast |

## Verification
The bench targets the race windows of the election. It raises another node's claim inside the first back-off and another node's activity inside the second. A design that checked only at back-off expiry would keep pulling and then drive a second clock onto the bus. Host hold and collision pulses are applied while in the master role, where a registered-only enable would leave the clock running one extra cycle. A collision sent to a device must leave the role untouched. Back-off lengths are measured for several seeds, including zero, and for the hold-off path, so an off-by-one counter or a wrong LFSR tap shows up as a shifted claim edge.

// File: rtl/sme_pkg.sv
package sme_pkg;

   typedef enum logic [2:0] {
      ST_START,
      ST_HOLD,
      ST_PROBE,
      ST_BACK1,
      ST_BACK2,
      ST_BCAST,
      ST_MASTER,
      ST_DEVICE
   } elect_state_e;

   // Feedback tap mask per supported LFSR width, zero for an unsupported width
   function automatic logic [31:0] lfsr_taps(input int width);
      case (width)
         8:       return 32'h0000_00B8;
         16:      return 32'h0000_B400;
         24:      return 32'h00E1_0000;
         32:      return 32'h8020_0003;
         default: return 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/sme_lfsr.sv
module sme_lfsr
   import sme_pkg::*;
#(
   parameter int W     = 16,
   parameter int OUT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     seed_i,
   output logic [OUT_W-1:0] rand_o
);
   localparam logic [31:0]  FULL_MASK = lfsr_taps(W);
   localparam logic [W-1:0] TAP_MASK  = FULL_MASK[W-1:0];

   generate
      if (FULL_MASK == 32'h0) begin : g_bad_width
         $error("sme_lfsr: width %0d has no tap set", W);
      end
      if (OUT_W > W || OUT_W < 1) begin : g_bad_out
         $error("sme_lfsr: OUT_W must lie in 1..W");
      end
   endgenerate

   logic [W-1:0] q;
   logic [W-1:0] seed_fix;
   logic         fb;

   assign seed_fix = (seed_i == '0) ? {{(W-1){1'b0}}, 1'b1} : seed_i;
   assign fb       = ^(q & TAP_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= seed_fix;
      else        q <= {q[W-2:0], fb};
   end

   assign rand_o = q[OUT_W-1:0];
endmodule

// File: rtl/sme_delay_map.sv
module sme_delay_map #(
   parameter int RAND_BITS = 8,
   parameter int CNT_W     = 17,
   parameter int MIN_TICKS = 1000,
   parameter int MAX_TICKS = 100000
) (
   input  logic [RAND_BITS-1:0] rand_i,
   output logic [CNT_W-1:0]     delay_o
);
   localparam int SPAN = MAX_TICKS - MIN_TICKS + 1;
   localparam int PW   = RAND_BITS + CNT_W + 1;

   generate
      if (SPAN == 1) begin : g_fixed
         logic unused_rand;
         assign unused_rand = ^rand_i;
         assign delay_o     = CNT_W'(MIN_TICKS);
      end else begin : g_scaled
         logic [PW-1:0] prod;
         assign prod    = PW'(rand_i) * PW'(SPAN);
         assign delay_o = CNT_W'(MIN_TICKS) + CNT_W'(prod >> RAND_BITS);
      end
   endgenerate
endmodule

// File: rtl/sme_timer.sv
module sme_timer #(
   parameter int CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] value_i,
   output logic             expire_o
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load_i)       cnt <= value_i;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expire_o = (cnt == CNT_W'(1));
endmodule

// File: rtl/sideband_master_elect.sv
module sideband_master_elect
   import sme_pkg::*;
#(
   parameter int LFSR_W     = 16,
   parameter int RAND_BITS  = 8,
   parameter int MIN_TICKS  = 1000,
   parameter int MAX_TICKS  = 100000,
   parameter int HOLD_TICKS = 250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prev_master_i,
   input  logic [LFSR_W-1:0] seed_i,
   input  logic              host_req_i,
   input  logic              claim_line_i,
   input  logic              act_line_i,
   input  logic              collision_i,
   input  logic              id_done_i,
   input  logic              xfer_busy_i,
   output logic              role_master_o,
   output logic              role_device_o,
   output logic              claim_pull_o,
   output logic              act_pull_o,
   output logic              sclk_en_o,
   output logic              id_start_o
);
   localparam int LONGEST = (MAX_TICKS > HOLD_TICKS) ? MAX_TICKS : HOLD_TICKS;
   localparam int CNT_W   = $clog2(LONGEST + 1);
   localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_TICKS);

   generate
      if (MIN_TICKS < 1) begin : g_bad_min
         $error("sideband_master_elect: MIN_TICKS must be at least 1");
      end
      if (MAX_TICKS < MIN_TICKS) begin : g_bad_max
         $error("sideband_master_elect: MAX_TICKS below MIN_TICKS");
      end
      if (HOLD_TICKS < 1) begin : g_bad_hold
         $error("sideband_master_elect: HOLD_TICKS must be at least 1");
      end
      if (RAND_BITS > LFSR_W) begin : g_bad_rand
         $error("sideband_master_elect: RAND_BITS exceeds LFSR_W");
      end
   endgenerate

   logic [RAND_BITS-1:0] rand_bits;
   logic [CNT_W-1:0]     rand_dly;
   logic [CNT_W-1:0]     ld_val;
   logic                 ld;
   logic                 expire;
   elect_state_e         st_q, st_d;
   logic                 ids_q, ids_d;

   sme_lfsr #(.W(LFSR_W), .OUT_W(RAND_BITS)) u_lfsr (
      .clk    (clk),
      .rst_n  (rst_n),
      .seed_i (seed_i),
      .rand_o (rand_bits)
   );

   sme_delay_map #(
      .RAND_BITS (RAND_BITS),
      .CNT_W     (CNT_W),
      .MIN_TICKS (MIN_TICKS),
      .MAX_TICKS (MAX_TICKS)
   ) u_map (
      .rand_i  (rand_bits),
      .delay_o (rand_dly)
   );

   sme_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (ld),
      .value_i  (ld_val),
      .expire_o (expire)
   );

   always_comb begin
      st_d   = st_q;
      ld     = 1'b0;
      ld_val = rand_dly;
      ids_d  = 1'b0;
      unique case (st_q)
         ST_START: begin
            if (prev_master_i) begin
               st_d = ST_PROBE;
            end else begin
               st_d   = ST_HOLD;
               ld     = 1'b1;
               ld_val = HOLD_V;
            end
         end
         ST_HOLD: begin
            if (expire) st_d = ST_PROBE;
         end
         ST_PROBE: begin
            if (host_req_i || claim_line_i) begin
               st_d = ST_DEVICE;
            end else begin
               st_d = ST_BACK1;
               ld   = 1'b1;
            end
         end
         ST_BACK1: begin
            if (host_req_i || claim_line_i) begin
               st_d = ST_DEVICE;
            end else if (expire) begin
               st_d = ST_BACK2;
               ld   = 1'b1;
            end
         end
         ST_BACK2: begin
            if (host_req_i || act_line_i) begin
               st_d = ST_DEVICE;
            end else if (expire) begin
               st_d  = ST_BCAST;
               ids_d = 1'b1;
            end
         end
         ST_BCAST: begin
            if (host_req_i)       st_d = ST_DEVICE;
            else if (collision_i) st_d = ST_PROBE;
            else if (id_done_i)   st_d = ST_MASTER;
         end
         ST_MASTER: begin
            if (host_req_i)       st_d = ST_DEVICE;
            else if (collision_i) st_d = ST_PROBE;
         end
         ST_DEVICE: begin
            if (!host_req_i && !claim_line_i) st_d = ST_PROBE;
         end
         default: st_d = ST_START;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_START;
         ids_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         ids_q <= ids_d;
      end
   end

   logic in_master;
   assign in_master     = (st_q == ST_BCAST) || (st_q == ST_MASTER);
   assign role_master_o = in_master;
   assign role_device_o = (st_q == ST_DEVICE);
   assign claim_pull_o  = in_master || (st_q == ST_BACK2);
   assign act_pull_o    = (st_q == ST_BCAST) || ((st_q == ST_MASTER) && xfer_busy_i);
   assign sclk_en_o     = in_master && !host_req_i && !collision_i;
   assign id_start_o    = ids_q;
endmodule

// File: rtl/sme_checker.sv
module sme_checker (
   input logic clk,
   input logic rst_n,
   input logic host_req_i,
   input logic claim_line_i,
   input logic act_line_i,
   input logic collision_i,
   input logic role_master_o,
   input logic role_device_o,
   input logic claim_pull_o,
   input logic act_pull_o,
   input logic sclk_en_o,
   input logic id_start_o
);
   assert_one_role_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(role_master_o && role_device_o));

   assert_quiet_device_R3: assert property (@(posedge clk) disable iff (!rst_n)
      role_device_o |-> (!claim_pull_o && !act_pull_o && !sclk_en_o));

   assert_act_needs_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
      act_pull_o |-> claim_pull_o);

   assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      id_start_o |=> !id_start_o);

   assert_strobe_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
      id_start_o |-> (role_master_o && act_pull_o));

   assert_claim_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(claim_pull_o) |-> !$past(claim_line_i));

   assert_act_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
      id_start_o |-> !$past(act_line_i));

   assert_host_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
      host_req_i |-> !sclk_en_o);

   assert_host_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (role_master_o && host_req_i) |=> (role_device_o && !claim_pull_o));

   assert_coll_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (role_master_o && collision_i) |=> (!role_master_o && !claim_pull_o && !act_pull_o));
endmodule

bind sideband_master_elect sme_checker u_sme_checker (.*);

// File: tb/tb_sideband_master_elect.sv
`timescale 1ns/1ps
module tb_sideband_master_elect;
   localparam int MINT = 3;
   localparam int MAXT = 12;
   localparam int HOLDT = 20;
   localparam int SPAN = MAXT - MINT + 1;

   localparam int S_START = 0, S_HOLD = 1, S_PROBE = 2, S_BACK1 = 3,
                  S_BACK2 = 4, S_BCAST = 5, S_MASTER = 6, S_DEVICE = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic prev_master = 1'b1;
   logic [15:0] seed = 16'h1;
   logic host_req = 1'b0, oth_claim = 1'b0, oth_act = 1'b0;
   logic coll = 1'b0, id_done = 1'b0, xfer = 1'b0;
   logic role_master, role_device, claim_pull, act_pull, sclk_en, id_start;
   logic claim_line, act_line;

   int vectors = 0;
   int misses = 0;
   int cycles = 0;
   bit wd_fired = 1'b0;
   string tag = "R1";

   assign claim_line = oth_claim | claim_pull;
   assign act_line   = oth_act | act_pull;

   always #2 clk = ~clk;

   sideband_master_elect #(
      .LFSR_W(16), .RAND_BITS(8), .MIN_TICKS(MINT), .MAX_TICKS(MAXT), .HOLD_TICKS(HOLDT)
   ) dut (
      .clk(clk), .rst_n(rst_n), .prev_master_i(prev_master), .seed_i(seed),
      .host_req_i(host_req), .claim_line_i(claim_line), .act_line_i(act_line),
      .collision_i(coll), .id_done_i(id_done), .xfer_busy_i(xfer),
      .role_master_o(role_master), .role_device_o(role_device),
      .claim_pull_o(claim_pull), .act_pull_o(act_pull),
      .sclk_en_o(sclk_en), .id_start_o(id_start)
   );

   // ---------------- behavioural reference ----------------
   function automatic logic [15:0] lfsr_next(logic [15:0] q);
      return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
   endfunction

   function automatic int backoff(logic [15:0] q);
      return MINT + ((int'(q[7:0]) * SPAN) >> 8);
   endfunction

   function automatic bit f_master(int s);
      return (s == S_BCAST) || (s == S_MASTER);
   endfunction

   function automatic bit f_claim(int s);
      return f_master(s) || (s == S_BACK2);
   endfunction

   function automatic bit f_act(int s, bit x);
      return (s == S_BCAST) || ((s == S_MASTER) && x);
   endfunction

   int m_st = S_START;
   int m_cnt = 0;
   logic [15:0] m_q = 16'h1;
   bit m_ids = 1'b0;

   always @(posedge clk) begin
      int nst;
      bit ld, nids, expd, cl, al;
      int lv;
      cycles++;
      if (!rst_n) begin
         m_st = S_START; m_cnt = 0; m_ids = 1'b0;
         m_q = (seed == 16'h0) ? 16'h1 : seed;
      end else begin
         cl   = oth_claim | f_claim(m_st);
         al   = oth_act | f_act(m_st, xfer);
         expd = (m_cnt == 1);
         nst  = m_st; ld = 1'b0; lv = backoff(m_q); nids = 1'b0;
         case (m_st)
            S_START:  if (prev_master) nst = S_PROBE;
                      else begin nst = S_HOLD; ld = 1'b1; lv = HOLDT; end
            S_HOLD:   if (expd) nst = S_PROBE;
            S_PROBE:  if (host_req || cl) nst = S_DEVICE;
                      else begin nst = S_BACK1; ld = 1'b1; end
            S_BACK1:  if (host_req || cl) nst = S_DEVICE;
                      else if (expd) begin nst = S_BACK2; ld = 1'b1; end
            S_BACK2:  if (host_req || al) nst = S_DEVICE;
                      else if (expd) begin nst = S_BCAST; nids = 1'b1; end
            S_BCAST:  if (host_req) nst = S_DEVICE;
                      else if (coll) nst = S_PROBE;
                      else if (id_done) nst = S_MASTER;
            S_MASTER: if (host_req) nst = S_DEVICE;
                      else if (coll) nst = S_PROBE;
            default:  if (!host_req && !cl) nst = S_PROBE;
         endcase
         if (ld) m_cnt = lv;
         else if (m_cnt != 0) m_cnt = m_cnt - 1;
         m_st  = nst;
         m_ids = nids;
         m_q   = lfsr_next(m_q);
      end
   end

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      logic [5:0] exp_v, act_v;
      if (rst_n) begin
         exp_v = {f_master(m_st), m_st == S_DEVICE, f_claim(m_st), f_act(m_st, xfer),
                  f_master(m_st) && !host_req && !coll, m_ids};
         act_v = {role_master, role_device, claim_pull, act_pull, sclk_en, id_start};
         vectors++;
         if (act_v !== exp_v) begin
            misses++;
            $display("FAIL %s cycle %0d outputs actual %b expected %b", tag, cycles, act_v, exp_v);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(bit ok, string req, string what, int actual, int expected);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, actual, expected);
      end
   endtask

   task automatic do_reset(bit pm, logic [15:0] sd);
      rst_n = 1'b0; prev_master = pm; seed = sd;
      host_req = 0; oth_claim = 0; oth_act = 0; coll = 0; id_done = 0; xfer = 0;
      tick(2);
      // R1: reset state
      check({role_master, role_device, claim_pull, act_pull, sclk_en, id_start} == 6'b0,
            "R1", "outputs in reset",
            int'({role_master, role_device, claim_pull, act_pull, sclk_en, id_start}), 0);
      rst_n = 1'b1;
   endtask

   task automatic wait_master(int lim, output int n);
      n = 0;
      while (!role_master && n < lim) begin tick(1); n++; end
      #1;
   endtask

   task automatic wait_claim(int lim, output int n);
      n = 0;
      while (!claim_pull && n < lim) begin tick(1); n++; end
      #1;
   endtask

   function automatic int expected_rise(bit pm, logic [15:0] sd);
      logic [15:0] q;
      int steps;
      q = (sd == 16'h0) ? 16'h1 : sd;
      steps = pm ? 1 : 1 + HOLDT;
      for (int i = 0; i < steps; i++) q = lfsr_next(q);
      return (pm ? 2 : 2 + HOLDT) + backoff(q);
   endfunction

   task automatic run_all;
      int n;
      // S1: fast restart, broadcast, transfer, collision
      tag = "R6";
      do_reset(1'b1, 16'hACE1);
      wait_master(200, n);
      check(role_master, "R6", "master reached", role_master, 1);
      check(id_start, "R6", "id strobe on entry", id_start, 1);
      check(act_pull && sclk_en, "R6", "activity pull and clock", act_pull & sclk_en, 1);
      tick(1); #1;
      check(!id_start, "R6", "strobe single cycle", id_start, 0);
      check(act_pull, "R12", "activity held before id_done", act_pull, 1);
      tag = "R12";
      id_done = 1'b1; tick(1); id_done = 1'b0; #1;
      check(!act_pull && role_master, "R12", "idle master releases activity", act_pull, 0);
      xfer = 1'b1; #1;
      check(act_pull, "R12", "activity follows transfer", act_pull, 1);
      tick(1); xfer = 1'b0; #1;
      check(!act_pull, "R12", "activity released", act_pull, 0);
      tag = "R9";
      coll = 1'b1; #1;
      check(!sclk_en, "R9", "clock off on collision", sclk_en, 0);
      tick(1); coll = 1'b0; #1;
      check(!role_master && !claim_pull && !act_pull, "R9", "lines released",
            int'({role_master, claim_pull, act_pull}), 0);
      wait_master(200, n);
      check(role_master, "R9", "re-election won", role_master, 1);

      // S2: device-role restart with hold-off
      tag = "R2";
      do_reset(1'b0, 16'h3C3C);
      wait_claim(500, n);
      check(n == expected_rise(1'b0, 16'h3C3C), "R2", "hold-off claim edge", n,
            expected_rise(1'b0, 16'h3C3C));

      // back-off lengths for several seeds, zero seed included
      tag = "R4";
      do_reset(1'b1, 16'hACE1); wait_claim(500, n);
      check(n == expected_rise(1'b1, 16'hACE1), "R4", "claim edge seed ACE1", n,
            expected_rise(1'b1, 16'hACE1));
      do_reset(1'b1, 16'h00FF); wait_claim(500, n);
      check(n == expected_rise(1'b1, 16'h00FF), "R4", "claim edge seed 00FF", n,
            expected_rise(1'b1, 16'h00FF));
      tag = "R5";
      do_reset(1'b1, 16'h0000); wait_claim(500, n);
      check(n == expected_rise(1'b1, 16'h0000), "R5", "zero seed claim edge", n,
            expected_rise(1'b1, 16'h0000));

      // S3: master already present, collision ignored, master leaves
      tag = "R3";
      do_reset(1'b1, 16'h7777);
      oth_claim = 1'b1;
      tick(5); #1;
      check(role_device && !claim_pull && !act_pull, "R3", "device when claimed",
            int'({role_device, claim_pull, act_pull}), 4);
      tag = "R10";
      coll = 1'b1; tick(1); coll = 1'b0; #1;
      check(role_device && !claim_pull, "R10", "collision ignored as device", role_device, 1);
      tag = "R11";
      oth_claim = 1'b0;
      wait_claim(200, n);
      check(claim_pull, "R11", "re-election after master left", claim_pull, 1);

      // S4: other claim during first back-off
      tag = "R7";
      do_reset(1'b1, 16'h1234);
      tick(3); oth_claim = 1'b1;
      tick(1); #1;
      check(role_device && !claim_pull, "R7", "abandon in first back-off", role_device, 1);
      oth_claim = 1'b0; tick(2);

      // S5: other activity during second back-off
      do_reset(1'b1, 16'h5A5A);
      wait_claim(200, n);
      oth_act = 1'b1;
      tick(1); #1;
      check(role_device && !claim_pull, "R7", "abandon in second back-off", role_device, 1);
      oth_act = 1'b0;
      wait_master(200, n);
      check(role_master, "R11", "won after activity cleared", role_master, 1);

      // S6: host hold while master
      tag = "R8";
      do_reset(1'b1, 16'h0F0F);
      wait_master(200, n);
      id_done = 1'b1; tick(1); id_done = 1'b0;
      host_req = 1'b1; #1;
      check(!sclk_en, "R8", "clock off with host request", sclk_en, 0);
      tick(1); #1;
      check(role_device, "R8", "device after host request", role_device, 1);
      tick(8); #1;
      check(role_device && !claim_pull, "R8", "stays device under hold", role_device, 1);
      host_req = 1'b0;
      wait_master(200, n);
      check(role_master, "R8", "master after hold released", role_master, 1);
      tick(3);
   endtask

   initial begin
      fork
         run_all();
         begin
            wait (cycles > 150000);
            wd_fired = 1'b1;
         end
      join_any
      if (wd_fired) begin
         misses++;
         $display("FAIL watchdog actual %0d expected below %0d", cycles, 150000);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule